// File: doc/BRIEF.md
# Hardware Scroll and Top-Blank Controller

This block sits in a character video generator between the raster timing generator and the display memory fetch logic. It decides which memory row is fetched for each character row on screen, and it blanks a programmable number of character rows at the top of the picture (a "window shade"). Software scrolls the screen by reprogramming the starting row and the shade depth. The text in display memory never has to move.

The CPU writes one byte through a write strobe. The low nibble selects the display memory row shown first. The high nibble sets how many character rows are blanked at the top. During vertical blanking the row sequencer is held in state `ST_HOLD`, with the row counter preset to the start row and the shade counter preset to the shade depth. When the active area begins, the transition `HOLD_TO_SHADE` is taken if the depth is non-zero and `HOLD_TO_DISP` if it is zero. In `ST_SHADE` the shade counter drops by one for every completed character row. When it reaches zero, `SHADE_TO_DISP` is taken. In `ST_DISP` the row address steps once per completed character row and wraps modulo 16. The transitions `SHADE_TO_HOLD` and `DISP_TO_HOLD` are taken when vertical blanking returns.

Each write also starts a pacing one-shot of 250 ms, derived from the clock frequency parameter. Its timer states are `TM_IDLE` and `TM_RUN`, with the transitions `TM_START`, `TM_RESTART` and `TM_EXPIRE`. Software reads the running flag on bit 0 of the read port, so it can pace scrolling without delay loops.

Top module: `scroll_shade_ctrl`

## Requirements
- R1: A write strobe latches wdata[3:0] as the start row. With a shade depth of zero, row_addr equals this start row on the first displayed scan line.
- R2: The same write latches wdata[7:4] as the shade depth N. pre_blank is high for exactly N*LINES_PER_ROW completed scan lines after the active area starts, and low after that.
- R3: While vblank is high, row_addr holds the latched start row and scan_line holds 0. A line_tick during vblank has no effect on either.
- R4: With a shade depth of zero, pre_blank is low from the first active cycle, and row_addr advances without delay.
- R5: In display, row_addr increments by one after every LINES_PER_ROW line ticks, and it wraps from 15 to 0.
- R6: While pre_blank is high in the active area, row_addr stays at the start row.
- R7: scan_line counts line ticks from 0 to LINES_PER_ROW-1 and then returns to 0.
- R8: A write starts the pacing timer. Read bit 0 is 1 for exactly TICKS = CLK_HZ/1000*PACE_MS cycles after the write edge, and 0 after that.
- R9: A write made while the timer is running restarts the full TICKS interval.
- R10: rdata is all zeros when rd_stb is low. When rd_stb is high, rdata[7:1] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle CPU write strobe for the scroll port |
| rd_stb | input | 1 | CPU read strobe for the scroll port |
| wdata | input | 8 | Write data: [3:0] start row, [7:4] shade depth |
| rdata | output | 8 | Read data: bit 0 is the timer running flag |
| vblank | input | 1 | High from the end of displayed text to the top of the next frame |
| line_tick | input | 1 | One-cycle pulse at the end of each horizontal scan line |
| row_addr | output | 4 | Display memory character row address |
| scan_line | output | LINE_W | Scan line within the current character row |
| pre_blank | output | 1 | High while the top rows are shaded |

## Verification
The hardest situation to reach from the ports is the hand-off from the shade countdown into display while the row address is close to 15. In that case the last shaded row, the first displayed row and the wrap to 0 all fall within a few character rows of each other. The stimulus runs many frames with random start rows and random shade depths, and keeps each frame long enough to cross the wrap. Directed frames add the extremes: a depth of zero, a depth of 15, and a start row of 15. A separate sequence pulses line_tick while vblank is high, to show that these pulses are ignored.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_SHADE = 2'd1,
        ST_DISP  = 2'd2
    } seq_state_t;

    typedef enum logic {
        TM_IDLE = 1'b0,
        TM_RUN  = 1'b1
    } tmr_state_t;

    localparam int ROW_W = 4;

endpackage

// File: rtl/scroll_regs.sv
module scroll_regs
    import scroll_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [7:0]       wdata,
    output logic [ROW_W-1:0] start_row,
    output logic [ROW_W-1:0] shade_rows
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_row  <= '0;
            shade_rows <= '0;
        end else if (wr_stb) begin
            start_row  <= wdata[3:0];
            shade_rows <= wdata[7:4];
        end
    end

    AST_LATCH_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (start_row == $past(wdata[3:0]) && shade_rows == $past(wdata[7:4]))); // R1

endmodule

// File: rtl/row_sequencer.sv
module row_sequencer
    import scroll_pkg::*;
#(
    parameter int LINES_PER_ROW = 10,
    localparam int LINE_W = (LINES_PER_ROW > 1) ? $clog2(LINES_PER_ROW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vblank,
    input  logic              line_tick,
    input  logic [ROW_W-1:0]  start_row,
    input  logic [ROW_W-1:0]  shade_rows,
    output logic [ROW_W-1:0]  row_addr,
    output logic [LINE_W-1:0] scan_line,
    output logic              pre_blank
);

    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_ROW - 1);

    seq_state_t        cur_q, nxt;
    logic [ROW_W-1:0]  row_q;
    logic [ROW_W-1:0]  blank_q;
    logic [LINE_W-1:0] line_q;
    logic              row_done;

    assign row_done = line_tick && !vblank && (cur_q != ST_HOLD) && (line_q == LAST_LINE);

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_HOLD: begin
                if (!vblank)
                    nxt = (blank_q == '0) ? ST_DISP : ST_SHADE;    // HOLD_TO_DISP / HOLD_TO_SHADE
            end
            ST_SHADE: begin
                if (vblank)
                    nxt = ST_HOLD;                                  // SHADE_TO_HOLD
                else if (row_done && blank_q == ROW_W'(1))
                    nxt = ST_DISP;                                  // SHADE_TO_DISP
            end
            ST_DISP: begin
                if (vblank)
                    nxt = ST_HOLD;                                  // DISP_TO_HOLD
            end
            default: nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= ST_HOLD;
        else
            cur_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            blank_q <= '0;
            line_q  <= '0;
        end else if (vblank || cur_q == ST_HOLD) begin
            row_q   <= start_row;
            blank_q <= shade_rows;
            line_q  <= '0;
        end else if (line_tick) begin
            line_q <= (line_q == LAST_LINE) ? '0 : line_q + LINE_W'(1);
            if (row_done) begin
                if (cur_q == ST_SHADE)
                    blank_q <= blank_q - ROW_W'(1);
                else
                    row_q <= row_q + ROW_W'(1);
            end
        end
    end

    always_comb begin
        row_addr  = row_q;
        scan_line = line_q;
        unique case (cur_q)
            ST_HOLD:  pre_blank = (blank_q != '0);
            ST_SHADE: pre_blank = 1'b1;
            ST_DISP:  pre_blank = 1'b0;
            default:  pre_blank = 1'b0;
        endcase
    end

    AST_HOLD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> (row_addr == $past(start_row) && scan_line == '0)); // R3

    AST_SHADE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_SHADE && !vblank) |=> $stable(row_addr)); // R6

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_DISP && row_done) |=> row_addr == $past(row_addr) + ROW_W'(1)); // R5

    AST_ZERO_SHADE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_HOLD && !vblank && blank_q == '0) |=> (cur_q == ST_DISP && !pre_blank)); // R4

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_line <= LAST_LINE); // R7

endmodule

// File: rtl/pace_timer.sv
module pace_timer
    import scroll_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int PACE_MS = 250,
    localparam int TICKS = (CLK_HZ / 1000 * PACE_MS < 2) ? 2 : CLK_HZ / 1000 * PACE_MS,
    localparam int CNT_W = $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    tmr_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TM_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                TM_IDLE: begin
                    if (start) begin                       // TM_START
                        st_q  <= TM_RUN;
                        cnt_q <= CNT_W'(TICKS - 1);
                    end
                end
                TM_RUN: begin
                    if (start) begin                       // TM_RESTART
                        cnt_q <= CNT_W'(TICKS - 1);
                    end else if (cnt_q == '0) begin        // TM_EXPIRE
                        st_q <= TM_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: st_q <= TM_IDLE;
            endcase
        end
    end

    always_comb begin
        busy = (st_q == TM_RUN);
    end

    AST_TMR_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && cnt_q == CNT_W'(TICKS - 1))); // R8

    AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> cnt_q == CNT_W'(TICKS - 1)); // R9

    AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - CNT_W'(1))); // R8

endmodule

// File: rtl/scroll_shade_ctrl.sv
module scroll_shade_ctrl
    import scroll_pkg::*;
#(
    parameter int LINES_PER_ROW = 10,
    parameter int CLK_HZ        = 50_000_000,
    parameter int PACE_MS       = 250,
    localparam int LINE_W = (LINES_PER_ROW > 1) ? $clog2(LINES_PER_ROW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              vblank,
    input  logic              line_tick,
    output logic [3:0]        row_addr,
    output logic [LINE_W-1:0] scan_line,
    output logic              pre_blank
);

    logic [ROW_W-1:0] start_row;
    logic [ROW_W-1:0] shade_rows;
    logic             tmr_busy;

    scroll_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wdata      (wdata),
        .start_row  (start_row),
        .shade_rows (shade_rows)
    );

    row_sequencer #(
        .LINES_PER_ROW (LINES_PER_ROW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .vblank     (vblank),
        .line_tick  (line_tick),
        .start_row  (start_row),
        .shade_rows (shade_rows),
        .row_addr   (row_addr),
        .scan_line  (scan_line),
        .pre_blank  (pre_blank)
    );

    pace_timer #(
        .CLK_HZ  (CLK_HZ),
        .PACE_MS (PACE_MS)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_stb),
        .busy  (tmr_busy)
    );

    always_comb begin
        rdata = 8'h00;
        if (rd_stb)
            rdata[0] = tmr_busy;
    end

    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[7:1] == 7'd0); // R10

    AST_RD_FLAG_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rd_stb) |=> (!rd_stb || rdata[0])); // R8

endmodule

// File: tb/tb_scroll_shade_ctrl.sv
module tb_scroll_shade_ctrl;

    localparam int LPR     = 3;
    localparam int CLK_HZ  = 8000;
    localparam int PACE_MS = 250;
    localparam int TICKS   = CLK_HZ / 1000 * PACE_MS;
    localparam int LW      = $clog2(LPR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic          rd_stb = 1'b0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic          vblank = 1'b1;
    logic          line_tick = 1'b0;
    logic [3:0]    row_addr;
    logic [LW-1:0] scan_line;
    logic          pre_blank;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    scroll_shade_ctrl #(
        .LINES_PER_ROW (LPR),
        .CLK_HZ        (CLK_HZ),
        .PACE_MS       (PACE_MS)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .wdata     (wdata),
        .rdata     (rdata),
        .vblank    (vblank),
        .line_tick (line_tick),
        .row_addr  (row_addr),
        .scan_line (scan_line),
        .pre_blank (pre_blank)
    );

    function automatic logic [3:0] exp_row(int s, int n, int k);
        int r = k / LPR;
        if (r < n) return 4'(s);
        return 4'((s + r - n) % 16);
    endfunction

    function automatic logic exp_pb(int n, int k);
        return (k / LPR) < n;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cpu_write(logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1;
        wdata  = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic run_frame(int s, int n, int lines);
        vblank = 1'b1;
        cpu_write({4'(n), 4'(s)});
        @(negedge clk);
        // R3: a line pulse during vblank is ignored
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
        @(negedge clk);
        check("R3 row", row_addr, s);
        check("R3 line", scan_line, 0);
        vblank = 1'b0;
        @(negedge clk);
        check(n == 0 ? "R4 pb" : "R2 pb", pre_blank, exp_pb(n, 0));
        check(n == 0 ? "R1 row" : "R6 row", row_addr, exp_row(s, n, 0));
        for (int k = 1; k <= lines; k++) begin
            line_tick = 1'b1;
            @(negedge clk);
            line_tick = 1'b0;
            if (($urandom % 3) == 0) @(negedge clk);
            check("R2 pb", pre_blank, exp_pb(n, k));
            check(exp_pb(n, k) ? "R6 row" : "R5 row", row_addr, exp_row(s, n, k));
            check("R7 line", scan_line, k % LPR);
        end
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R3 hold", row_addr, s);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R10 reset rdata", rdata, 0);
        check("R3 reset row", row_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_stb = 1'b1;
        #1;
        check("R8 idle flag", rdata, 0);
        rd_stb = 1'b0;

        // directed corners
        run_frame(5, 0, 20);
        run_frame(15, 0, 8);
        run_frame(14, 15, 15 * LPR + 10);
        run_frame(0, 1, 12);

        // random frames
        for (int f = 0; f < 25; f++) begin
            int s = $urandom % 16;
            int n = $urandom % 16;
            run_frame(s, n, n * LPR + 5 + ($urandom % 40));
        end

        // pacing timer: let it expire first
        repeat (TICKS + 5) @(negedge clk);
        rd_stb = 1'b1;
        #1;
        check("R8 expired", rdata, 0);
        rd_stb = 1'b0;

        cpu_write(8'h3A);
        rd_stb = 1'b1;
        #1;
        check("R8 run start", rdata, 1);
        repeat (TICKS - 1) @(negedge clk);
        #1;
        check("R8 last run cycle", rdata, 1);
        @(negedge clk);
        #1;
        check("R8 expire", rdata, 0);
        rd_stb = 1'b0;
        #1;
        check("R10 no read", rdata, 0);

        // restart mid-run
        cpu_write(8'h00);
        repeat (TICKS / 2) @(negedge clk);
        cpu_write(8'h11);
        repeat (TICKS - 1) @(negedge clk);
        rd_stb = 1'b1;
        #1;
        check("R9 restart still running", rdata, 1);
        check("R10 upper bits", rdata & 8'hFE, 0);
        rd_stb = 1'b0;
        #1;
        check("R10 strobe low", rdata, 0);
        @(negedge clk);
        rd_stb = 1'b1;
        #1;
        check("R9 restart expire", rdata, 0);
        rd_stb = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule